// File: doc/BRIEF.md
# Variable Bit Field Extractor

This block pulls a bit field of run-time length out of a bit string that lives in byte-addressed memory. The caller supplies a base byte address, a signed bit position measured from bit 0 of the base byte, a signed field size and a mode flag. The block then makes one read of a five-byte window through its memory port. It shifts the window so that the field starts at bit 0, masks away everything above the field and returns a 32-bit result with a one-cycle done pulse.

The five-byte window covers every field of up to 32 bits, including one that starts at bit 7 of its first byte. Sizes outside the legal range are clamped, so no size raises an error. A size of 32 or more acts as 32, and a negative size acts as 0. In zero mode the bits above the field are cleared. In sign mode they are filled with the field's top bit.

Top module: `bitfield_extract`

## Requirements
- R1: A start accepted while idle raises `mem_req_o` for exactly one cycle, in the cycle after the start edge. The address in that cycle is `base_addr_i + floor(bit_pos_i / 8)`, taken modulo 2^ADDR_W.
- R2: Bit b of the string is bit (b mod 8) of the byte at address base + floor(b / 8). Result bit i is string bit `bit_pos_i + i`. On `mem_rdata_i`, byte k (bits 8k+7..8k) holds the byte at `mem_addr_o + k`, so the lowest address is the least significant byte.
- R3: A size of 32 or larger extracts exactly 32 bits.
- R4: A negative size (bit 31 of `bit_len_i` set) gives a result of zero in both modes.
- R5: A size of zero gives a result of zero in both modes.
- R6: With `sext_i` = 0, result bits at and above the clamped size are zero.
- R7: With `sext_i` = 1 and a clamped size n from 1 to 31, result bits n..31 all equal result bit n-1.
- R8: `done_o` is a one-cycle pulse in the third cycle after the start edge, and `result_o` is valid from that cycle. `busy_o` is high in the two cycles before it. A new start is accepted in the cycle in which `done_o` is high.
- R9: A start pulse while `busy_o` is high is ignored. The running operation's address and result are unchanged, and no extra request or done pulse follows.
- R10: After reset, `busy_o`, `done_o` and `mem_req_o` are low and `result_o` is zero.
- R11: A negative bit position addresses bytes below the base, using floor division. For example, position -1 is bit 7 of byte base-1, and the address wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request an extraction (taken only when idle) |
| base_addr_i | input | ADDR_W | Base byte address of the bit string |
| bit_pos_i | input | POS_W | Signed bit position of the field's low bit |
| bit_len_i | input | POS_W | Signed field size in bits |
| sext_i | input | 1 | 1: sign-extend the field, 0: zero-extend |
| mem_req_o | output | 1 | Memory read strobe |
| mem_addr_o | output | ADDR_W | Byte address of the window's lowest byte |
| mem_rdata_i | input | 8*WIN_BYTES | Window data, one cycle after the request |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Result valid pulse |
| result_o | output | RES_W | Extracted field, extended to RES_W bits |

## Verification
The cases hardest to reach from the ports lie at the window edges. One is a 32-bit field at bit offset 7, which needs the fifth byte. Another is a negative position near address zero, which must wrap the byte address. The bench aims directed operations at both and at sizes just around the clamp limits. It then runs a long random mix whose positions span both signs and all eight offsets. It also issues a second start in the request cycle with different operands, and one in the done cycle, to probe the ignore rule and back-to-back acceptance.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_WAIT = 2'd2
   } bfx_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/bfx_ctrl.sv
module bfx_ctrl
   import bfx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic accept,
   output logic mem_req,
   output logic capture,
   output logic busy,
   output logic done
);

   bfx_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (start) state_d = ST_REQ;
         ST_REQ:  state_d = ST_WAIT;
         ST_WAIT: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         done    <= 1'b0;
      end else begin
         state_q <= state_d;
         done    <= (state_q == ST_WAIT);
      end
   end

   assign accept  = start && (state_q == ST_IDLE);
   assign mem_req = (state_q == ST_REQ);
   assign capture = (state_q == ST_WAIT);
   assign busy    = (state_q != ST_IDLE);

   AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> (!mem_req && busy)); // R1
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8
   AST_DONE_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (done && !busy)); // R8
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && start) |=> (capture && !mem_req)); // R9

endmodule

// File: rtl/bfx_addr_gen.sv
module bfx_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int POS_W  = 32,
   parameter int RES_W  = 32,
   localparam int OFF_W = 3,
   localparam int LEN_W = $clog2(RES_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [POS_W-1:0]  bit_pos,
   input  logic [POS_W-1:0]  bit_len,
   input  logic              sext,
   output logic [ADDR_W-1:0] win_addr_q,
   output logic [OFF_W-1:0]  offset_q,
   output logic [LEN_W-1:0]  len_q,
   output logic              sext_q
);

   logic signed [POS_W-1:0] pos_s;
   logic signed [POS_W-1:0] byte_step;
   logic [ADDR_W-1:0]       step_ext;
   logic [ADDR_W-1:0]       addr_d;
   logic [LEN_W-1:0]        len_d;

   assign pos_s     = $signed(bit_pos);
   assign byte_step = pos_s >>> OFF_W;
   assign step_ext  = ADDR_W'(byte_step);
   assign addr_d    = base_addr + step_ext;

   always_comb begin
      if (bit_len[POS_W-1])
         len_d = '0;
      else if (bit_len >= POS_W'(RES_W))
         len_d = LEN_W'(RES_W);
      else
         len_d = bit_len[LEN_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_addr_q <= '0;
         offset_q   <= '0;
         len_q      <= '0;
         sext_q     <= 1'b0;
      end else if (load) begin
         win_addr_q <= addr_d;
         offset_q   <= bit_pos[OFF_W-1:0];
         len_q      <= len_d;
         sext_q     <= sext;
      end
   end

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (len_q <= LEN_W'(RES_W))); // R3

endmodule

// File: rtl/bfx_align.sv
module bfx_align #(
   parameter int WIN_W     = 40,
   parameter int RES_W     = 32,
   parameter int OFF_W     = 3,
   parameter int LEN_W     = 6,
   parameter bit LOG_SHIFT = 1'b1
) (
   input  logic [WIN_W-1:0] win,
   input  logic [OFF_W-1:0] offset,
   input  logic [LEN_W-1:0] len,
   input  logic             sext,
   output logic [RES_W-1:0] field
);

   localparam int IDX_W = LEN_W - 1;

   logic [WIN_W-1:0] shifted;
   logic [RES_W-1:0] low;
   logic [RES_W-1:0] keep;
   logic [LEN_W-1:0] top_idx;
   logic             fill_bit;

   generate
      if (LOG_SHIFT) begin : g_log_shift
         logic [WIN_W-1:0] stage [OFF_W+1];
         assign stage[0] = win;
         for (genvar k = 0; k < OFF_W; k++) begin : g_stage
            assign stage[k+1] = offset[k] ? (stage[k] >> (1 << k)) : stage[k];
         end
         assign shifted = stage[OFF_W];
      end else begin : g_flat_shift
         assign shifted = win >> offset;
      end
   endgenerate

   assign low     = shifted[RES_W-1:0];
   assign top_idx = len - LEN_W'(1);
   assign fill_bit = sext && (len != '0) && low[top_idx[IDX_W-1:0]];

   generate
      for (genvar i = 0; i < RES_W; i++) begin : g_mask
         assign keep[i]  = (LEN_W'(i) < len);
         assign field[i] = keep[i] ? low[i] : fill_bit;
      end
   endgenerate

endmodule

// File: rtl/bitfield_extract.sv
module bitfield_extract
   import bfx_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int POS_W     = 32,
   parameter int RES_W     = 32,
   parameter int WIN_BYTES = 5,
   parameter bit LOG_SHIFT = 1'b1,
   localparam int WIN_W    = 8 * WIN_BYTES,
   localparam int OFF_W    = 3,
   localparam int LEN_W    = $clog2(RES_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [POS_W-1:0]  bit_pos_i,
   input  logic [POS_W-1:0]  bit_len_i,
   input  logic              sext_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   input  logic [WIN_W-1:0]  mem_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [RES_W-1:0]  result_o
);

   generate
      if (!is_pow2(RES_W)) begin : g_bad_res
         $error("RES_W must be a power of two");
      end
      if (WIN_W < RES_W + 7) begin : g_bad_win
         $error("window too narrow for a field at bit offset 7");
      end
      if (POS_W <= LEN_W) begin : g_bad_pos
         $error("POS_W must exceed the clamped size width");
      end
   endgenerate

   logic              accept;
   logic              capture;
   logic [OFF_W-1:0]  offset_q;
   logic [LEN_W-1:0]  len_q;
   logic              sext_q;
   logic [RES_W-1:0]  field;

   bfx_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_i),
      .accept  (accept),
      .mem_req (mem_req_o),
      .capture (capture),
      .busy    (busy_o),
      .done    (done_o)
   );

   bfx_addr_gen #(
      .ADDR_W (ADDR_W),
      .POS_W  (POS_W),
      .RES_W  (RES_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .base_addr  (base_addr_i),
      .bit_pos    (bit_pos_i),
      .bit_len    (bit_len_i),
      .sext       (sext_i),
      .win_addr_q (mem_addr_o),
      .offset_q   (offset_q),
      .len_q      (len_q),
      .sext_q     (sext_q)
   );

   bfx_align #(
      .WIN_W     (WIN_W),
      .RES_W     (RES_W),
      .OFF_W     (OFF_W),
      .LEN_W     (LEN_W),
      .LOG_SHIFT (LOG_SHIFT)
   ) u_align (
      .win    (mem_rdata_i),
      .offset (offset_q),
      .len    (len_q),
      .sext   (sext_q),
      .field  (field)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         result_o <= '0;
      else if (capture)
         result_o <= field;
   end

   AST_ZERO_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && len_q == '0) |=> (result_o == '0)); // R5
   AST_ZEXT_HIGH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !sext_q && len_q < LEN_W'(RES_W)) |=> ((result_o >> len_q) == '0)); // R6
   AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(result_o)); // R8

endmodule

// File: tb/bitfield_extract_bench.sv
module bitfield_extract_bench;

   localparam int ADDR_W = 32;
   localparam int WIN_W  = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [ADDR_W-1:0] base_addr_i = '0;
   logic [31:0]       bit_pos_i = '0;
   logic [31:0]       bit_len_i = '0;
   logic              sext_i = 1'b0;
   logic              mem_req_o;
   logic [ADDR_W-1:0] mem_addr_o;
   logic [WIN_W-1:0]  mem_rdata_i = '0;
   logic              busy_o;
   logic              done_o;
   logic [31:0]       result_o;

   int n_vec = 0;
   int n_bad = 0;
   int cycles = 0;
   bit summary_done = 1'b0;

   always #4 clk = ~clk;

   bitfield_extract u_bitfield_extract (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_i),
      .base_addr_i (base_addr_i),
      .bit_pos_i   (bit_pos_i),
      .bit_len_i   (bit_len_i),
      .sext_i      (sext_i),
      .mem_req_o   (mem_req_o),
      .mem_addr_o  (mem_addr_o),
      .mem_rdata_i (mem_rdata_i),
      .busy_o      (busy_o),
      .done_o      (done_o),
      .result_o    (result_o)
   );

   // Memory contents are a fixed hash of the byte address.
   function automatic logic [7:0] mbyte(input logic [31:0] a);
      logic [31:0] t;
      t = a * 32'd2654435761;
      return t[31:24] ^ t[7:0] ^ 8'h3C;
   endfunction

   always @(posedge clk) begin
      if (mem_req_o)
         for (int k = 0; k < 5; k++) mem_rdata_i[8*k +: 8] <= mbyte(mem_addr_o + 32'(k));
   end

   function automatic logic [31:0] ref_extract(input logic [31:0] base, input int pos,
                                               input int len, input bit sx);
      int n;
      logic [31:0] r;
      longint b0;
      n = (len < 0) ? 0 : ((len > 32) ? 32 : len);
      r = '0;
      b0 = longint'(base) * 8 + longint'(pos);
      for (int i = 0; i < n; i++) begin
         longint bi;
         logic [7:0] by;
         bi = b0 + longint'(i);
         by = mbyte(32'(bi >>> 3));
         r[i] = by[3'(bi & 7)];
      end
      if (sx && n > 0 && n < 32 && r[n-1])
         for (int i = n; i < 32; i++) r[i] = 1'b1;
      return r;
   endfunction

   // Reference model: phase 0 idle, 1 request, 2 wait, 3 done (also idle).
   int          m_phase = 0;
   logic [31:0] m_addr = '0;
   logic [31:0] m_pend = '0;
   logic [31:0] m_res = '0;
   string       m_tag = "R10";
   string       m_pend_tag = "R10";
   string       cur_tag = "R6";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0;
         m_res = '0;
         m_tag = "R10";
      end else begin
         case (m_phase)
            1: m_phase = 2;
            2: begin
               m_phase = 3;
               m_res = m_pend;
               m_tag = m_pend_tag;
            end
            default: begin
               if (start_i) begin
                  m_phase = 1;
                  m_addr = base_addr_i + 32'($signed(bit_pos_i) >>> 3);
                  m_pend = ref_extract(base_addr_i, $signed(bit_pos_i), $signed(bit_len_i), sext_i);
                  m_pend_tag = cur_tag;
               end else begin
                  m_phase = 0;
               end
            end
         endcase
      end
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         check("R1 mem_req_o", 32'(mem_req_o), 32'(m_phase == 1));
         check("R8 busy_o", 32'(busy_o), 32'(m_phase == 1 || m_phase == 2));
         check("R8 done_o", 32'(done_o), 32'(m_phase == 3));
         if (m_phase == 1) check("R1/R11 mem_addr_o", mem_addr_o, m_addr);
         if (m_phase == 3 || m_phase == 0) check({m_tag, " result_o"}, result_o, m_res);
      end
   end

   task automatic op(input logic [31:0] base, input int pos, input int len,
                     input bit sx, input string tag);
      @(negedge clk);
      cur_tag = tag;
      base_addr_i = base;
      bit_pos_i = 32'(pos);
      bit_len_i = 32'(len);
      sext_i = sx;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
   endtask

   initial begin : watchdog
      while (cycles < 200000) @(negedge clk);
      if (!summary_done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary_done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stimulus
      repeat (3) @(negedge clk);
      check("R10 busy_o in reset", 32'(busy_o), 0);
      check("R10 done_o in reset", 32'(done_o), 0);
      check("R10 mem_req_o in reset", 32'(mem_req_o), 0);
      check("R10 result_o in reset", result_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      op(32'h100, 0, 8, 1'b0, "R2");
      op(32'h100, 13, 11, 1'b0, "R2");
      op(32'h200, 7, 32, 1'b0, "R3");
      op(32'h200, 7, 32, 1'b1, "R3");
      op(32'h204, 3, 40, 1'b0, "R3");
      op(32'h204, 3, 32'h7FFF_FFFF, 1'b1, "R3");
      op(32'h300, 5, -1, 1'b0, "R4");
      op(32'h300, 5, -32, 1'b1, "R4");
      op(32'h300, 9, 0, 1'b0, "R5");
      op(32'h300, 9, 0, 1'b1, "R5");
      for (int p = 0; p < 16; p++) begin
         op(32'h400, p, 31, 1'b0, "R6");
         op(32'h400, p, 1 + p, 1'b1, "R7");
         op(32'h400, p, 31, 1'b1, "R7");
      end
      op(32'h500, -1, 1, 1'b0, "R11");
      op(32'h500, -1, 8, 1'b1, "R11");
      op(32'h500, -37, 20, 1'b0, "R11");
      op(32'h0, -3, 12, 1'b0, "R11");
      op(32'h1, -20, 32, 1'b1, "R11");
      op(32'hFFFF_FFFE, 19, 32, 1'b0, "R1");

      // R9: a start in the request cycle with other operands is ignored.
      @(negedge clk);
      cur_tag = "R9";
      base_addr_i = 32'h600; bit_pos_i = 32'd4; bit_len_i = 32'd12; sext_i = 1'b0;
      start_i = 1'b1;
      @(negedge clk);
      cur_tag = "R9 ignored";
      base_addr_i = 32'h9000; bit_pos_i = 32'd1; bit_len_i = 32'd5; sext_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);

      // R8: back-to-back starts, the second taken in the done cycle.
      @(negedge clk);
      cur_tag = "R8";
      base_addr_i = 32'h700; bit_pos_i = 32'd6; bit_len_i = 32'd17; sext_i = 1'b1;
      start_i = 1'b1;
      repeat (3) @(negedge clk);
      base_addr_i = 32'h740; bit_pos_i = 32'd2; bit_len_i = 32'd30; sext_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (4) @(negedge clk);

      for (int n = 0; n < 600; n++) begin
         int pos;
         int len;
         pos = $signed($urandom_range(0, 4000)) - 2000;
         len = $signed($urandom_range(0, 44)) - 4;
         op($urandom, pos, len, 1'(n & 1), (n & 1) ? "R7" : "R6");
      end

      repeat (3) @(negedge clk);
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule